// File: doc/BRIEF.md
# MFM Write Precompensation Unit

This unit sits just ahead of the write driver of a rotating-media write channel. It takes a serial MFM cell stream and emits one short write pulse for every `1` cell. Clock cells and data cells alternate in the stream. Each pulse lands on one of three taps of a fast oversampling clock: early, nominal or late. The tap is picked from the cells around the transition, so that peak shift on playback is pre-cancelled.

The unit keeps a seven-cell window around the cell being written: three cells of look-behind and three of look-ahead. A classifier turns that window into a shift code, and a tick timer turns the code into a tap. One cell lasts `CELL_TICKS` fast-clock cycles, and taps are one fast-clock period apart. The nominal tap sits in the middle of the cell. Compensation is gated by the current cylinder number: only the inner zone `ZONE_LO..ZONE_HI` gets shifted, and elsewhere every transition is written at the nominal tap.

The cell input is a valid/ready stream. `in_ready` rises only in the last tick of a cell period and stays high until a cell is taken. A source that holds `in_valid` low stretches the current cell period; no pulse and no state change happens during the wait. `cyl` is a plain level, sampled when a cell is accepted.

Top module: `wpc_precomp`

## Requirements
- R1: After reset the window holds all zeros, `wr_pulse` is 0, `cell_shift` is 00 and `in_ready` is 1.
- R2: A cell is accepted on a clock edge with `in_valid` and `in_ready` both high. `in_ready` is low for the following CELL_TICKS-1 cycles, then stays high until the next acceptance. A stalled source causes no pulse.
- R3: The first cell accepted after reset is a clock cell, and cells then alternate clock, data, clock and so on.
- R4: A data cell of value 1 is written late when the previous data cell is 0 and the next data cell is 1.
- R5: A data cell of value 1 is written early when the previous data cell is 1 and the next data cell is 0.
- R6: A clock cell of value 1 is written late when the data cell three positions before it is 1 and the data cell three positions after it is 0.
- R7: A clock cell of value 1 is written early when the data cell three positions before it is 0 and the data cell three positions after it is 1.
- R8: Every other `1` cell is written at the nominal tap, and a `0` cell produces no pulse. Cells before the first accepted one count as 0.
- R9: Shifting applies only when `cyl`, sampled at acceptance, lies in ZONE_LO..ZONE_HI inclusive (defaults 128 and 152). Outside that range every pulse is nominal.
- R10: Cell k is written during the period that starts with the acceptance of cell k+3. Its pulse is one cycle wide and is first visible CELL_TICKS/2+1 cycles after that acceptance edge. An early pulse comes one cycle sooner and a late pulse one cycle later.
- R11: `cell_shift` reports the code of the cell being written (00 nominal, 01 early, 10 late). It changes only at an acceptance edge and is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Cell stream valid |
| in_ready | output | 1 | Unit takes a cell this cycle |
| in_cell | input | 1 | Cell value (1 = transition) |
| cyl | input | CYL_W | Current cylinder number |
| wr_pulse | output | 1 | One-cycle write pulse at the chosen tap |
| cell_shift | output | 2 | Shift code of the cell being written |

## Verification
The bench goes after the window edges. The first cells after reset must see zero fill; a design that seeded the window wrongly would shift or emit pulses for cells that were never sent. The cylinder limits 127, 128, 152 and 153 are exercised, which exposes an off-by-one zone compare as a shifted pulse outside the zone or a nominal pulse inside it. Random stalls between cells would show a timer that advanced while waiting as a misplaced pulse. Streams that mix clock and data cells would show a swapped parity or mirrored look-ahead as early and late pulses trading places.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  // Shift code carried with each written cell
  typedef enum logic [1:0] {
    SHIFT_NOM   = 2'b00,
    SHIFT_EARLY = 2'b01,
    SHIFT_LATE  = 2'b10
  } shift_e;

  // Cells of look-behind and look-ahead around the written cell
  localparam int LOOK = 3;
  localparam int WIN  = 2 * LOOK + 1;
endpackage

// File: rtl/wpc_cell_window.sv
// Cell shift register with clock/data parity of the centre cell.
// win[0] is the newest cell, win[WIN-1] the oldest.
module wpc_cell_window
  import wpc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           cell_in,
  output logic [WIN-1:0] win_next,
  output logic           centre_is_data_next
);
  logic [WIN-1:0] win_q;
  logic           par_q;

  assign win_next[0] = cell_in;
  generate
    for (genvar i = 1; i < WIN; i++) begin : g_stage
      assign win_next[i] = win_q[i-1];
    end
  endgenerate

  // Reset centre is fill cell -4, an even (clock) position
  assign centre_is_data_next = ~par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      par_q <= 1'b0;
    end else if (shift_en) begin
      win_q <= win_next;
      par_q <= ~par_q;
    end
  end
endmodule

// File: rtl/wpc_zone.sv
// Inner-zone detector for the cylinder number.
module wpc_zone #(
  parameter int CYL_W   = 8,
  parameter int ZONE_LO = 128,
  parameter int ZONE_HI = 152
) (
  input  logic [CYL_W-1:0] cyl,
  output logic             in_zone
);
  localparam logic [CYL_W-1:0] LO_V = CYL_W'(ZONE_LO);
  localparam logic [CYL_W-1:0] HI_V = CYL_W'(ZONE_HI);

  assign in_zone = (cyl >= LO_V) && (cyl <= HI_V);
endmodule

// File: rtl/wpc_classifier.sv
// Picks early, late or nominal for the centre cell of the window.
module wpc_classifier
  import wpc_pkg::*;
(
  input  logic [WIN-1:0] win,
  input  logic           is_data,
  input  logic           zone_en,
  output shift_e         code
);
  localparam int C = LOOK;

  logic near_prev, near_next, far_prev, far_next;
  assign near_prev = win[C+2];
  assign near_next = win[C-2];
  assign far_prev  = win[C+3];
  assign far_next  = win[C-3];

  always_comb begin
    code = SHIFT_NOM;
    if (win[C] && zone_en) begin
      if (is_data) begin
        if (!near_prev && near_next)      code = SHIFT_LATE;
        else if (near_prev && !near_next) code = SHIFT_EARLY;
      end else begin
        if (far_prev && !far_next)        code = SHIFT_LATE;
        else if (!far_prev && far_next)   code = SHIFT_EARLY;
      end
    end
  end
endmodule

// File: rtl/wpc_tap_timer.sv
// Cell-period tick counter and tap selection for the write pulse.
module wpc_tap_timer
  import wpc_pkg::*;
#(
  parameter int CELL_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       val_d,
  input  shift_e     code_d,
  output logic       ready,
  output logic       pulse,
  output logic [1:0] code_o
);
  localparam int TICK_W = $clog2(CELL_TICKS);
  localparam logic [TICK_W-1:0] LAST  = TICK_W'(CELL_TICKS - 1);
  localparam logic [TICK_W-1:0] NOM_T = TICK_W'(CELL_TICKS / 2);
  localparam logic [TICK_W-1:0] ERL_T = TICK_W'(CELL_TICKS / 2 - 1);
  localparam logic [TICK_W-1:0] LAT_T = TICK_W'(CELL_TICKS / 2 + 1);

  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] tap;
  logic              val_q;
  shift_e            code_q;

  always_comb begin
    case (code_q)
      SHIFT_EARLY: tap = ERL_T;
      SHIFT_LATE:  tap = LAT_T;
      default:     tap = NOM_T;
    endcase
  end

  assign ready  = (tick_q == LAST);
  assign code_o = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= LAST;
      val_q  <= 1'b0;
      code_q <= SHIFT_NOM;
      pulse  <= 1'b0;
    end else begin
      if (accept) begin
        tick_q <= '0;
        val_q  <= val_d;
        code_q <= code_d;
      end else if (tick_q != LAST) begin
        tick_q <= tick_q + 1'b1;
      end
      pulse <= val_q && (tick_q == tap);
    end
  end
endmodule

// File: rtl/wpc_precomp.sv
// Write precompensation unit top level.
module wpc_precomp
  import wpc_pkg::*;
#(
  parameter int CELL_TICKS = 8,
  parameter int CYL_W      = 8,
  parameter int ZONE_LO    = 128,
  parameter int ZONE_HI    = 152
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_cell,
  input  logic [CYL_W-1:0] cyl,
  output logic             wr_pulse,
  output logic [1:0]       cell_shift
);
  logic           accept;
  logic [WIN-1:0] win_next;
  logic           is_data_next;
  logic           in_zone;
  shift_e         code_next;

  assign accept = in_valid && in_ready;

  wpc_cell_window u_win (
    .clk                 (clk),
    .rst_n               (rst_n),
    .shift_en            (accept),
    .cell_in             (in_cell),
    .win_next            (win_next),
    .centre_is_data_next (is_data_next)
  );

  wpc_zone #(
    .CYL_W   (CYL_W),
    .ZONE_LO (ZONE_LO),
    .ZONE_HI (ZONE_HI)
  ) u_zone (
    .cyl     (cyl),
    .in_zone (in_zone)
  );

  wpc_classifier u_cls (
    .win     (win_next),
    .is_data (is_data_next),
    .zone_en (in_zone),
    .code    (code_next)
  );

  wpc_tap_timer #(
    .CELL_TICKS (CELL_TICKS)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .val_d  (win_next[LOOK]),
    .code_d (code_next),
    .ready  (in_ready),
    .pulse  (wr_pulse),
    .code_o (cell_shift)
  );
endmodule

// File: rtl/wpc_precomp_chk.sv
module wpc_precomp_chk #(
  parameter int CYL_W   = 8,
  parameter int ZONE_LO = 128,
  parameter int ZONE_HI = 152
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CYL_W-1:0] cyl,
  input logic             wr_pulse,
  input logic [1:0]       cell_shift
);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R2
  ready_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  // R10
  pulse_not_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !in_ready);
  // R9
  outer_zone_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (int'(cyl) < ZONE_LO || int'(cyl) > ZONE_HI))
      |=> (cell_shift == 2'b00));
  // R11
  code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_shift));
  // R11
  code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(cell_shift));
endmodule

bind wpc_precomp wpc_precomp_chk #(
  .CYL_W   (CYL_W),
  .ZONE_LO (ZONE_LO),
  .ZONE_HI (ZONE_HI)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cyl        (cyl),
  .wr_pulse   (wr_pulse),
  .cell_shift (cell_shift)
);

// File: tb/sim_wpc_precomp.sv
`timescale 1ns/1ps
module sim_wpc_precomp;
  localparam int CT  = 8;
  localparam int NOM = CT / 2;
  localparam int LO  = 128;
  localparam int HI  = 152;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_cell = 1'b0;
  logic [7:0] cyl = 8'd140;
  logic       in_ready, wr_pulse;
  logic [1:0] cell_shift;

  int errors = 0, checks = 0;
  int n_acc = 0, cnt = CT;
  bit started = 1'b0, done = 1'b0;
  bit hist [8192];
  int cylh [8192];
  bit prev_d = 1'b0;

  always #2 clk = ~clk;

  wpc_precomp #(.CELL_TICKS(CT), .CYL_W(8), .ZONE_LO(LO), .ZONE_HI(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cell(in_cell), .cyl(cyl), .wr_pulse(wr_pulse), .cell_shift(cell_shift));

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cell count %0d)", tag, act, exp, n_acc);
    end
  endtask

  function automatic bit h(int i);
    if (i < 0 || i >= n_acc) return 1'b0;
    return hist[i];
  endfunction

  // Expected code for cell m, with the cylinder sampled at acceptance of m+3
  function automatic void classify(int m, output logic [1:0] code, output string tag);
    bit a, d, shifted;
    logic [1:0] raw;
    raw = 2'b00;
    tag = "R8";
    if (h(m)) begin
      if (m % 2 == 1) begin  // R3: odd positions carry data
        a = h(m - 2); d = h(m + 2);
        if (!a && d)      begin raw = 2'b10; tag = "R3 R4"; end
        else if (a && !d) begin raw = 2'b01; tag = "R3 R5"; end
      end else begin
        a = h(m - 3); d = h(m + 3);
        if (a && !d)      begin raw = 2'b10; tag = "R3 R6"; end
        else if (!a && d) begin raw = 2'b01; tag = "R3 R7"; end
      end
    end
    shifted = (raw != 2'b00);
    if (shifted && (cylh[m + 3] < LO || cylh[m + 3] > HI)) begin
      raw = 2'b00; tag = "R9";
    end else if (shifted) begin
      tag = {tag, " R9"};
    end
    code = raw;
  endfunction

  // Monitor: sample away from the active edge
  always @(negedge clk) begin
    int m, off;
    bit ev, ep;
    logic [1:0] ec;
    string tg;
    if (rst_n && started) begin
      m = n_acc - 1 - 3;
      ev = h(m);
      ec = 2'b00; tg = "R8";
      if (n_acc > 0) classify(m, ec, tg);
      if (cnt == 1 && n_acc > 0)
        check(cell_shift == ec, {"R11 ", tg}, cell_shift, ec);
      off = (ec == 2'b01) ? -1 : ((ec == 2'b10) ? 1 : 0);
      ep = ev && (cnt == NOM + 2 + off);
      check(wr_pulse == ep, {"R10 ", tg}, wr_pulse, ep);
      check(in_ready == (cnt >= CT), "R2 ready", in_ready, cnt >= CT);
      if (in_valid && in_ready) begin
        hist[n_acc] = in_cell;
        cylh[n_acc] = cyl;
        n_acc++;
        cnt = 1;
      end else if (cnt < 1000) begin
        cnt++;
      end
    end
  end

  task automatic send_cell(bit v, int c, int gap);
    repeat (gap) begin @(posedge clk); #1; in_valid = 1'b0; end
    @(posedge clk); #1;
    in_valid = 1'b1; in_cell = v; cyl = 8'(c);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, int c);
    for (int i = 7; i >= 0; i--) begin
      send_cell(!prev_d && !b[i], c, 0);
      send_cell(b[i], c, 0);
      prev_d = b[i];
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(wr_pulse == 1'b0, "R1 pulse", wr_pulse, 0);
    check(cell_shift == 2'b00, "R1 code", cell_shift, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    started = 1'b1;
    // R3 R7: early clock cell right after the zero fill
    send_cell(1'b1, 140, 0);
    send_cell(1'b0, 140, 0);
    send_cell(1'b0, 140, 0);
    send_cell(1'b1, 140, 0);
    // R4..R8: MFM bytes at the zone limits (R9)
    for (int z = 0; z < 5; z++) begin
      int c;
      c = (z == 0) ? 127 : (z == 1) ? 128 : (z == 2) ? 152 : (z == 3) ? 153 : 140;
      send_byte(8'h00, c);
      send_byte(8'h70, c);
      send_byte(8'h8E, c);
      send_byte(8'hFF, c);
      send_byte(8'h5A, c);
    end
    // R2: stalls between cells
    for (int i = 0; i < 40; i++) send_cell(i[0] ^ i[2], 140, i % 4);
    // Random cells, cylinders and stalls
    begin
      int c;
      c = 140;
      for (int i = 0; i < 1600; i++) begin
        int gap;
        if (i % 32 == 0) begin
          case ($urandom % 8)
            0: c = 127; 1: c = 128; 2: c = 152; 3: c = 153;
            4: c = 0;   5: c = 255; default: c = $urandom % 256;
          endcase
        end
        gap = ($urandom % 5 == 0) ? int'($urandom % 4) : 0;
        send_cell(1'($urandom % 2), c, gap);
      end
    end
    // Flush so the last cells are written
    for (int i = 0; i < 4; i++) send_cell(1'b0, 140, 0);
    repeat (2 * CT) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule